// File: doc/BRIEF.md
# Two-Phase Regulator Startup and Protection Sequencer

This block is the digital control core of a two-phase step-down regulator. It consumes already-digitised comparator flags (two supply-good indications, an enable, a phase-2 presence detect, three feedback window comparisons, an over-current trip and an over-temperature trip) and produces the PWM enables for both phases, a power-good flag, a single-phase flag and a two-bit sequencer status with a four-bit latched fault record.

After both supplies are good and the enable is high, the sequencer runs a soft start of `SS_LEN` clocks and then regulates. It samples the phase-2 detect input once, `T1_DLY` clocks into the soft start, to choose between two-phase and single-phase operation. A two-phase choice may later fall back to single-phase exactly once, and single-phase never reverts to two-phase until the next power cycle. Every fault flag passes through a glitch filter of `DG_LEN` clocks before it acts, and a fault stops switching until a supply or the enable is dropped.

Top module: `dual_phase_seq`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, status is OFF (code 0), both PWM enables, power-good, the single-phase flag and all fault bits are 0.
- R2: The block leaves OFF only when both supply-good inputs and the enable are high; the status then reads SOFT (code 1) one clock later. If any of the three is low at a clock edge, the status is OFF after that edge, and fault bits and power-good are cleared.
- R3: Soft start lasts exactly `SS_LEN` clocks; the status then changes to RUN (code 2) unless a fault intervenes.
- R4: The phase-2 detect input is sampled at the edge `T1_DLY` clocks after the SOFT status first appears: low keeps two-phase operation, high sets the single-phase flag. Before that edge the flag is 0.
- R5: Once the single-phase flag is set, it stays set whatever the detect input does until the status returns to OFF.
- R6: After a two-phase choice, a high detect input at any later edge sets the single-phase flag; the phase-2 PWM enable goes low and does not return.
- R7: Power-good rises one clock after the feedback-above-power-good flag is seen high in RUN, and stays high while the status is RUN, even if that flag falls.
- R8: A fault flag acts only after it has been high for `DG_LEN` consecutive edges; a shorter pulse has no effect on status or fault bits.
- R9: A filtered over-voltage, over-current or over-temperature flag in SOFT or RUN, or a filtered under-voltage flag in RUN only, moves the status to FAULT (code 3), drops both PWM enables and power-good, and sets its fault bit (bit 0 under-voltage, bit 1 over-voltage, bit 2 over-current, bit 3 over-temperature).
- R10: FAULT status and its fault bits hold while supplies and enable stay high, even after the fault flag clears.
- R11: The phase-1 PWM enable is high exactly in SOFT and RUN; the phase-2 enable equals the phase-1 enable with the single-phase flag low.
- R12: A filtered fault present at the edge that would end soft start wins: the status goes to FAULT, not RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Main supply above its good threshold |
| vdrv_ok | input | 1 | Internal driver supply above its good threshold |
| enable | input | 1 | Enable / reference-present flag |
| ph2_absent | input | 1 | Phase-2 detect: high means phase 2 unavailable |
| fb_above_pg | input | 1 | Feedback above power-good threshold |
| fb_below_uv | input | 1 | Feedback below under-voltage threshold |
| fb_above_ov | input | 1 | Feedback above over-voltage threshold |
| ocp_trip | input | 1 | Current sense beyond the over-current limit |
| otp_trip | input | 1 | Die over-temperature flag |
| pwm_en | output | 1 | Phase-1 PWM enable |
| ph2_pwm_en | output | 1 | Phase-2 PWM enable |
| single_phase | output | 1 | Single-phase operation selected |
| power_good | output | 1 | Output in regulation |
| seq_status | output | 2 | 0 OFF, 1 SOFT, 2 RUN, 3 FAULT |
| fault_flags | output | 4 | Latched fault causes, bit order as in R9 |

## Verification
Two functions can meet on one clock edge: the soft-start terminal count and a fault flag whose glitch filter completes at that very edge, and likewise the power-good set in RUN against an under-voltage trip. The bench times an over-current pulse so that its filter saturates exactly one edge before the terminal count and expects FAULT rather than RUN with only the over-current bit set; random fault bursts against a cycle model exercise the power-good collision and the phase-latch strobe coinciding with trips.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2,
        ST_FLT  = 2'd3
    } seq_state_e;

    localparam int NUM_FLT = 4;

    typedef struct packed {
        logic ot;
        logic oc;
        logic ov;
        logic uv;
    } flt_vec_t;

    // Under-voltage is not meaningful while the output is still ramping.
    function automatic flt_vec_t soft_mask(input flt_vec_t f);
        flt_vec_t m;
        m    = f;
        m.uv = 1'b0;
        return m;
    endfunction

    function automatic flt_vec_t active_trips(input seq_state_e st, input flt_vec_t f);
        case (st)
            ST_RUN:  return f;
            ST_SOFT: return soft_mask(f);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/dps_deglitch.sv
module dps_deglitch #(
    parameter int DG_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(DG_LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(DG_LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!raw) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign filt = (cnt_q == TOP);

    AST_DG_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !raw |=> !filt);  // R8

endmodule

// File: rtl/dps_phase_sel.sv
module dps_phase_sel (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic smp,
    input  logic det,
    output logic single
);
    logic decided_q;
    logic single_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            decided_q <= 1'b0;
            single_q  <= 1'b0;
        end else if (smp && !decided_q) begin
            decided_q <= 1'b1;
            single_q  <= det;
        end else if (decided_q && det) begin
            single_q  <= 1'b1;
        end
    end

    assign single = single_q;

    AST_SINGLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (single_q && !clr) |=> single_q);  // R5

    AST_SINGLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(single_q) |-> $past(det));  // R6

endmodule

// File: rtl/dps_ctrl_fsm.sv
module dps_ctrl_fsm
    import dps_pkg::*;
#(
    parameter int SS_LEN = 256,
    parameter int T1_DLY = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_en,
    input  logic       fb_pg,
    input  flt_vec_t   flt_in,
    output seq_state_e state,
    output logic       pgood,
    output flt_vec_t   faults,
    output logic       t1_strobe
);
    localparam int SSW = (SS_LEN > 1) ? $clog2(SS_LEN) : 1;
    localparam logic [SSW-1:0] SS_LAST = SSW'(SS_LEN - 1);
    localparam logic [SSW-1:0] T1_IDX  = SSW'(T1_DLY - 1);

    seq_state_e     state_q;
    logic [SSW-1:0] ss_q;
    logic           pgood_q;
    flt_vec_t       flt_q;
    flt_vec_t       trip_vec;
    logic           trip;

    assign trip_vec = active_trips(state_q, flt_in);
    assign trip     = |trip_vec;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            state_q <= ST_OFF;
            ss_q    <= '0;
            pgood_q <= 1'b0;
            flt_q   <= '0;
        end else begin
            case (state_q)
                ST_OFF: begin
                    state_q <= ST_SOFT;
                    ss_q    <= '0;
                end
                ST_SOFT: begin
                    if (trip) begin
                        state_q <= ST_FLT;
                        flt_q   <= flt_q | trip_vec;
                    end else if (ss_q == SS_LAST) begin
                        state_q <= ST_RUN;
                    end else begin
                        ss_q <= ss_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (trip) begin
                        state_q <= ST_FLT;
                        flt_q   <= flt_q | trip_vec;
                        pgood_q <= 1'b0;
                    end else if (fb_pg) begin
                        pgood_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign state     = state_q;
    assign pgood     = pgood_q;
    assign faults    = flt_q;
    assign t1_strobe = (state_q == ST_SOFT) && (ss_q == T1_IDX);

    AST_DROP_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> state_q == ST_OFF);  // R2

    AST_PG_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        pgood_q |-> state_q == ST_RUN);  // R7

    AST_UV_MASKED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SOFT && run_en && !flt_in.ov && !flt_in.oc && !flt_in.ot)
        |=> state_q != ST_FLT);  // R9

    AST_FLT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLT && run_en) |=> (state_q == ST_FLT && $stable(flt_q)));  // R10

    AST_FLT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FLT |-> flt_q != '0);  // R9

endmodule

// File: rtl/dual_phase_seq.sv
module dual_phase_seq
    import dps_pkg::*;
#(
    parameter int SS_LEN = 256,
    parameter int T1_DLY = 64,
    parameter int DG_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_ok,
    input  logic       vdrv_ok,
    input  logic       enable,
    input  logic       ph2_absent,
    input  logic       fb_above_pg,
    input  logic       fb_below_uv,
    input  logic       fb_above_ov,
    input  logic       ocp_trip,
    input  logic       otp_trip,
    output logic       pwm_en,
    output logic       ph2_pwm_en,
    output logic       single_phase,
    output logic       power_good,
    output logic [1:0] seq_status,
    output logic [3:0] fault_flags
);
    logic [NUM_FLT-1:0] flt_raw;
    logic [NUM_FLT-1:0] flt_filt;
    flt_vec_t           flt_s;
    flt_vec_t           flt_lat;
    seq_state_e         st;
    logic               run_en;
    logic               t1_strobe;
    logic               single_s;

    assign run_en  = vcc_ok && vdrv_ok && enable;
    assign flt_raw = {otp_trip, ocp_trip, fb_above_ov, fb_below_uv};

    for (genvar gi = 0; gi < NUM_FLT; gi++) begin : g_dg
        dps_deglitch #(.DG_LEN(DG_LEN)) u_dg (
            .clk  (clk),
            .rst  (rst),
            .raw  (flt_raw[gi]),
            .filt (flt_filt[gi])
        );
    end

    assign flt_s = flt_vec_t'(flt_filt);

    dps_ctrl_fsm #(.SS_LEN(SS_LEN), .T1_DLY(T1_DLY)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .run_en    (run_en),
        .fb_pg     (fb_above_pg),
        .flt_in    (flt_s),
        .state     (st),
        .pgood     (power_good),
        .faults    (flt_lat),
        .t1_strobe (t1_strobe)
    );

    dps_phase_sel u_phase (
        .clk    (clk),
        .rst    (rst),
        .clr    (st == ST_OFF),
        .smp    (t1_strobe),
        .det    (ph2_absent),
        .single (single_s)
    );

    assign pwm_en       = (st == ST_SOFT) || (st == ST_RUN);
    assign ph2_pwm_en   = pwm_en && !single_s;
    assign single_phase = single_s;
    assign seq_status   = st;
    assign fault_flags  = flt_lat;

    AST_PH2_SUBSET: assert property (@(posedge clk) disable iff (rst)
        ph2_pwm_en |-> (pwm_en && !single_phase));  // R11

endmodule

// File: tb/tb_dual_phase_seq.sv
module tb_dual_phase_seq;
    localparam int SS = 24;
    localparam int T1 = 6;
    localparam int DG = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic vcc = 0, vdrv = 0, en = 0, ph2 = 0, fbpg = 0;
    logic uv = 0, ov = 0, oc = 0, ot = 0;
    logic       pwm, ph2en, single, pg;
    logic [1:0] status;
    logic [3:0] flt;

    dual_phase_seq #(.SS_LEN(SS), .T1_DLY(T1), .DG_LEN(DG)) dut (
        .clk(clk), .rst(rst), .vcc_ok(vcc), .vdrv_ok(vdrv), .enable(en),
        .ph2_absent(ph2), .fb_above_pg(fbpg), .fb_below_uv(uv),
        .fb_above_ov(ov), .ocp_trip(oc), .otp_trip(ot),
        .pwm_en(pwm), .ph2_pwm_en(ph2en), .single_phase(single),
        .power_good(pg), .seq_status(status), .fault_flags(flt)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit cmp_on = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // cycle model built from the requirements
    int       m_st, m_ss;
    int       m_dg [4];
    bit       m_pg, m_dec, m_sg;
    bit [3:0] m_fl;

    always @(posedge clk) begin : model
        int ost, oss;
        bit ok;
        bit [3:0] f, raw, tv;
        if (rst) begin
            m_st = 0; m_ss = 0; m_pg = 0; m_dec = 0; m_sg = 0; m_fl = 0;
            for (int i = 0; i < 4; i++) m_dg[i] = 0;
        end else begin
            ost = m_st; oss = m_ss;
            ok  = vcc && vdrv && en;
            raw = {ot, oc, ov, uv};
            for (int i = 0; i < 4; i++) begin
                f[i] = (m_dg[i] == DG);
                m_dg[i] = raw[i] ? ((m_dg[i] < DG) ? m_dg[i] + 1 : DG) : 0;
            end
            if (ost == 0) begin
                m_dec = 0; m_sg = 0;
            end else if (ost == 1 && oss == T1 - 1 && !m_dec) begin
                m_dec = 1; m_sg = ph2;
            end else if (m_dec && ph2) begin
                m_sg = 1;
            end
            tv = (ost == 2) ? f : (ost == 1) ? (f & 4'b1110) : 4'b0000;
            if (!ok) begin
                m_st = 0; m_ss = 0; m_pg = 0; m_fl = 0;
            end else begin
                case (ost)
                    0: begin m_st = 1; m_ss = 0; end
                    1: if (tv != 0) begin m_st = 3; m_fl = m_fl | tv; end
                       else if (oss == SS - 1) m_st = 2;
                       else m_ss = oss + 1;
                    2: if (tv != 0) begin m_st = 3; m_fl = m_fl | tv; m_pg = 0; end
                       else if (fbpg) m_pg = 1;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && cmp_on) begin
            bit mp;
            mp = (m_st == 1) || (m_st == 2);
            chk("R3 status vs model", int'(status), m_st);
            chk("R11 pwm_en vs model", int'(pwm), int'(mp));
            chk("R4 ph2_pwm_en vs model", int'(ph2en), int'(mp && !m_sg));
            chk("R6 single_phase vs model", int'(single), int'(m_sg));
            chk("R7 power_good vs model", int'(pg), int'(m_pg));
            chk("R9 fault_flags vs model", int'(flt), int'(m_fl));
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R3 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int burst [4];
        bit [3:0] fr;
        void'($urandom(32'd20240517));
        for (int i = 0; i < 4; i++) burst[i] = 0;

        wait_n(3);
        chk("R1 reset status", int'(status), 0);
        chk("R1 reset pwm", int'(pwm), 0);
        chk("R1 reset ph2", int'(ph2en), 0);
        chk("R1 reset pgood", int'(pg), 0);
        chk("R1 reset faults", int'(flt), 0);
        rst = 1'b0;
        cmp_on = 1'b1;
        wait_n(1);
        chk("R1 first cycle after reset", int'(status), 0);

        // supplies up, enable low: stays off
        vcc = 1; vdrv = 1;
        wait_n(2);
        chk("R2 no start without enable", int'(status), 0);
        en = 1;
        wait_n(1);
        chk("R2 soft start entered", int'(status), 1);
        chk("R11 pwm in soft start", int'(pwm), 1);
        wait_n(SS - 1);
        chk("R3 still soft before terminal", int'(status), 1);
        wait_n(1);
        chk("R3 run after SS_LEN", int'(status), 2);
        chk("R4 two-phase selected", int'(ph2en), 1);
        fbpg = 1;
        wait_n(1);
        chk("R7 power good rises", int'(pg), 1);
        fbpg = 0;
        wait_n(2);
        chk("R7 power good held", int'(pg), 1);
        ph2 = 1;
        wait_n(1);
        chk("R6 drop to single", int'(single), 1);
        chk("R6 phase2 off", int'(ph2en), 0);
        ph2 = 0;
        wait_n(3);
        chk("R6 no return to dual", int'(ph2en), 0);

        // glitch filter
        ov = 1; wait_n(DG - 1); ov = 0;
        wait_n(4);
        chk("R8 short pulse ignored status", int'(status), 2);
        chk("R8 short pulse ignored faults", int'(flt), 0);
        ov = 1;
        wait_n(DG);
        chk("R8 not yet tripped", int'(status), 2);
        wait_n(1);
        chk("R9 ov fault status", int'(status), 3);
        chk("R9 ov fault bit", int'(flt), 4'b0010);
        chk("R9 pwm off in fault", int'(pwm), 0);
        chk("R9 pgood off in fault", int'(pg), 0);
        ov = 0;
        wait_n(5);
        chk("R10 fault held", int'(status), 3);
        chk("R10 fault bits held", int'(flt), 4'b0010);
        vdrv = 0;
        wait_n(1);
        chk("R2 supply loss to off", int'(status), 0);
        chk("R2 faults cleared", int'(flt), 0);

        // single-phase from start
        ph2 = 1; vdrv = 1;
        wait_n(1);
        chk("R2 restart", int'(status), 1);
        wait_n(T1 - 1);
        chk("R4 flag low before sample", int'(single), 0);
        wait_n(1);
        chk("R4 single latched", int'(single), 1);
        chk("R4 phase2 held off", int'(ph2en), 0);
        ph2 = 0;
        wait_n(SS);
        chk("R5 single sticky", int'(single), 1);
        chk("R5 status run", int'(status), 2);

        // dual latch, under-voltage during soft start masked
        en = 0;
        wait_n(2);
        chk("R5 cleared in off", int'(single), 0);
        en = 1;
        wait_n(T1 + 1);
        chk("R4 dual latched", int'(single), 0);
        chk("R4 phase2 running", int'(ph2en), 1);
        uv = 1;
        wait_n(SS - T1);
        chk("R9 uv masked in soft", int'(status), 2);
        wait_n(1);
        chk("R9 uv fault in run", int'(status), 3);
        chk("R9 uv fault bit", int'(flt), 4'b0001);
        uv = 0;

        // fault on the terminal-count edge
        en = 0;
        wait_n(2);
        en = 1;
        wait_n(SS - DG);
        oc = 1;
        wait_n(DG);
        chk("R12 still soft", int'(status), 1);
        wait_n(1);
        chk("R12 fault beats run", int'(status), 3);
        chk("R12 oc bit only", int'(flt), 4'b0100);
        oc = 0;

        // over-temperature during soft start
        en = 0;
        wait_n(2);
        en = 1;
        wait_n(3);
        ot = 1;
        wait_n(DG + 1);
        chk("R9 ot fault status", int'(status), 3);
        chk("R9 ot fault bit", int'(flt), 4'b1000);
        ot = 0;

        // constrained random, compared against the model each cycle
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            vcc  = vcc  ? ($urandom_range(0, 399) != 0) : ($urandom_range(0, 7) == 0);
            vdrv = vdrv ? ($urandom_range(0, 399) != 0) : ($urandom_range(0, 7) == 0);
            en   = en   ? ($urandom_range(0, 399) != 0) : ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 2) == 0) fbpg = $urandom_range(0, 1);
            if ($urandom_range(0, 39) == 0) ph2 = ~ph2;
            for (int i = 0; i < 4; i++) begin
                if (burst[i] > 0) burst[i]--;
                else if ($urandom_range(0, 199) == 0) burst[i] = $urandom_range(1, 6);
                fr[i] = (burst[i] != 0);
            end
            uv = fr[0]; ov = fr[1]; oc = fr[2]; ot = fr[3];
        end

        wait_n(2);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule